// File: doc/BRIEF.md
# Per-Port Interrupt Cause Register

This block keeps the interrupt causes of one storage-controller port. Twelve single-cycle event inputs, from the command engine, the link layer and the error counters, each set a sticky cause bit. A separate twelve-bit enable mask decides which causes reach the port interrupt line. Software reads one 32-bit word that carries each cause twice: once gated by its enable in the low half, and once ungated in the upper half.

Causes are dismissed by write-one-to-clear through either copy. Enables change only through a set register and a clear register. The command-complete cause can also be dismissed by a slot-status read, and the three error-threshold causes by a write to their counter. Each of those side paths has its own pulse input.

The cause positions are: 0 command complete, 1 command error, 2 port ready, 3 power-state change, 4 PHY ready change, 5 wake signal received, 6 unknown frame received, 7 device swapped, 8 decode-error limit, 9 CRC-error limit, 10 handshake-error limit, 11 set-device-bits notice.

Top module: `port_irq_ctrl`

## Requirements
- R1: After reset, all cause bits and all enables are 0, `rd_status` reads 0 and `irq_o` is 0.
- R2: A pulse on `evt_i[n]` sets cause n at the next clock edge. From then on, `rd_status[16+n]` reads 1 and `rd_status[n]` reads cause n ANDed with enable n.
- R3: A write with `wr_sel`=0 clears cause n when `wr_data[n]` or `wr_data[16+n]` is 1. Zero data bits leave causes unchanged.
- R4: A write with `wr_sel`=1 sets enable n for each 1 in `wr_data[n]`. A write with `wr_sel`=2 clears enable n for each 1 in `wr_data[n]`. Zero bits have no effect, and `enables_o` shows the mask.
- R5: When an event and a clear of the same cause land in the same cycle, the event wins and the cause stays set.
- R6: With `w1c_mode_i`=0, a `slot_rd_i` pulse clears cause 0. With `w1c_mode_i`=1, `slot_rd_i` has no effect.
- R7: While `cmd_mask_i` is 1, a pulse on `evt_i[0]` does not set cause 0.
- R8: A pulse on `cnt_wr_i[k]` (k = 0, 1, 2) clears cause 8+k.
- R9: `irq_o` is 1 exactly when some cause is both set and enabled.
- R10: `rd_status` bits 12 to 15 and 28 to 31 always read 0. Data written to those bits, or to enable bits 12 and above, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 12 | One-cycle event pulses, one per cause |
| cmd_mask_i | input | 1 | Suppresses the completion event of the current command |
| w1c_mode_i | input | 1 | 1: only an explicit write clears cause 0 |
| slot_rd_i | input | 1 | Pulse for a slot-status read |
| cnt_wr_i | input | 3 | Pulses for writes to the three error counters |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 status clear, 1 enable set, 2 enable clear, 3 none |
| wr_data | input | 32 | Write data |
| rd_status | output | 32 | Masked causes [11:0], raw causes [27:16] |
| enables_o | output | 12 | Current enable mask |
| irq_o | output | 1 | Port interrupt |

## Verification
Events are raised while their enables are off and then while they are on. This shows that the raw and masked halves differ only by the mask, and that the interrupt line follows the masked half alone. Clears are applied through the low copy, the high copy and zero data, which separates a decode error on either copy from a write that wrongly touches anything. A clear is also made to collide with a fresh event. The side paths are tried in both mode settings and against causes they must not touch: slot reads, counter writes and the command-level mask.

// File: rtl/port_irq_ctrl.sv
module port_irq_ctrl #(
  parameter int NCAUSE   = 12,
  parameter int RAW_OFS  = 16,
  parameter int DW       = 32,
  parameter int THR_BASE = 8,
  parameter int NTHR     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] evt_i,
  input  logic              cmd_mask_i,
  input  logic              w1c_mode_i,
  input  logic              slot_rd_i,
  input  logic [NTHR-1:0]   cnt_wr_i,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_status,
  output logic [NCAUSE-1:0] enables_o,
  output logic              irq_o
);
  localparam logic [1:0] SEL_STAT  = 2'd0;
  localparam logic [1:0] SEL_ENSET = 2'd1;
  localparam logic [1:0] SEL_ENCLR = 2'd2;

  logic [NCAUSE-1:0] st_q, en_q, set_v, clr_v, side_clr, en_set, en_clr, masked;
  logic stat_wr;
  logic unused_bits;

  assign stat_wr = wr_en && (wr_sel == SEL_STAT);
  assign en_set  = (wr_en && wr_sel == SEL_ENSET) ? wr_data[NCAUSE-1:0] : '0;
  assign en_clr  = (wr_en && wr_sel == SEL_ENCLR) ? wr_data[NCAUSE-1:0] : '0;
  assign clr_v   = (stat_wr ? (wr_data[NCAUSE-1:0] | wr_data[RAW_OFS +: NCAUSE]) : '0) | side_clr;

  for (genvar g = 0; g < NCAUSE; g++) begin : g_cause
    if (g == 0) begin : g_cc
      assign set_v[g]    = evt_i[g] && !cmd_mask_i;
      assign side_clr[g] = slot_rd_i && !w1c_mode_i;
    end else if (g >= THR_BASE && g < THR_BASE + NTHR) begin : g_thr
      assign set_v[g]    = evt_i[g];
      assign side_clr[g] = cnt_wr_i[g-THR_BASE];
    end else begin : g_plain
      assign set_v[g]    = evt_i[g];
      assign side_clr[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= set_v | (st_q & ~clr_v);
      en_q <= en_set | (en_q & ~en_clr);
    end
  end

  assign masked = st_q & en_q;

  always_comb begin
    rd_status = '0;
    rd_status[NCAUSE-1:0]        = masked;
    rd_status[RAW_OFS +: NCAUSE] = st_q;
  end

  assign enables_o = en_q;
  assign irq_o     = |masked;
  assign unused_bits = ^{wr_data[DW-1:RAW_OFS+NCAUSE], wr_data[RAW_OFS-1:NCAUSE]};
endmodule

module port_irq_ctrl_chk #(
  parameter int NCAUSE = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCAUSE-1:0] evt_i,
  input logic              cmd_mask_i,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [31:0]       wr_data,
  input logic [31:0]       rd_status,
  input logic [NCAUSE-1:0] enables_o,
  input logic              irq_o
);
  a_r2_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[1] |=> rd_status[17]);
  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[2] && wr_en && wr_sel == 2'd0 && wr_data[2]) |=> rd_status[18]);
  a_r4_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && wr_data[0]) |=> enables_o[0]);
  a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[0]) |=> !enables_o[0]);
  a_r7_masked_completion: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[0] && cmd_mask_i && !rd_status[16]) |=> !rd_status[16]);
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (enables_o != '0) && (rd_status[27:16] != '0));
  a_r10_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status[15:12] == 4'h0) && (rd_status[31:28] == 4'h0));
endmodule

bind port_irq_ctrl port_irq_ctrl_chk #(.NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cmd_mask_i(cmd_mask_i),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_status(rd_status), .enables_o(enables_o), .irq_o(irq_o)
);

// File: tb/port_irq_ctrl_tb.sv
module port_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] evt_i = '0;
  logic cmd_mask_i = 1'b0, w1c_mode_i = 1'b0, slot_rd_i = 1'b0;
  logic [2:0] cnt_wr_i = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_status;
  logic [11:0] enables_o;
  logic irq_o;

  always #5 clk = ~clk;

  port_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cmd_mask_i(cmd_mask_i),
    .w1c_mode_i(w1c_mode_i), .slot_rd_i(slot_rd_i), .cnt_wr_i(cnt_wr_i),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_status(rd_status), .enables_o(enables_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] st;
    logic [11:0] en;
    logic        irq;
    string       req;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nfail = 0;
  logic [11:0] m_st = '0, m_en = '0;

  task automatic check(input exp_t e);
    nchk++;
    if (rd_status !== e.st || enables_o !== e.en || irq_o !== e.irq) begin
      nfail++;
      $display("FAIL %s: status=%h en=%h irq=%b expected status=%h en=%h irq=%b",
               e.req, rd_status, enables_o, irq_o, e.st, e.en, e.irq);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) check(q.pop_front());
  end

  task automatic op(input logic [11:0] evt, input logic we, input logic [1:0] sel,
                    input logic [31:0] dat, input logic mode, input logic slot,
                    input logic cmask, input logic [2:0] cnt, input string req);
    logic [11:0] setv, clrv;
    exp_t e;
    @(negedge clk);
    evt_i = evt; wr_en = we; wr_sel = sel; wr_data = dat;
    w1c_mode_i = mode; slot_rd_i = slot; cmd_mask_i = cmask; cnt_wr_i = cnt;
    setv = evt;
    if (cmask) setv[0] = 1'b0;
    clrv = '0;
    if (we && sel == 2'd0) clrv = dat[11:0] | dat[27:16];
    if (slot && !mode) clrv[0] = 1'b1;
    clrv[10:8] = clrv[10:8] | cnt;
    m_st = setv | (m_st & ~clrv);
    if (we && sel == 2'd1) m_en = m_en | dat[11:0];
    if (we && sel == 2'd2) m_en = m_en & ~dat[11:0];
    e.st = {4'h0, m_st, 4'h0, m_st & m_en};
    e.en = m_en;
    e.irq = |(m_st & m_en);
    e.req = req;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    slot_rd_i = 1'b0; cmd_mask_i = 1'b0; cnt_wr_i = '0;
  endtask

  initial begin
    exp_t e0;
    repeat (3) @(posedge clk);
    #2;
    e0.st = '0; e0.en = '0; e0.irq = 1'b0; e0.req = "R1 reset";
    check(e0);
    @(negedge clk);
    rst_n = 1'b1;
    op(12'h00A, 0, 2'd3, 32'h0, 0, 0, 0, 3'b000, "R2 raw only, R9 no irq");
    op(12'h000, 1, 2'd1, 32'h0000_0008, 0, 0, 0, 3'b000, "R4 enable set, R9 irq");
    op(12'h000, 1, 2'd1, 32'h0, 0, 0, 0, 3'b000, "R4 zero set write");
    op(12'h000, 1, 2'd0, 32'h0, 0, 0, 0, 3'b000, "R3 zero clear write");
    op(12'h000, 1, 2'd0, 32'h0000_0008, 0, 0, 0, 3'b000, "R3 clear via low copy");
    op(12'h000, 1, 2'd0, 32'h0002_0000, 0, 0, 0, 3'b000, "R3 clear via raw copy");
    op(12'h004, 0, 2'd3, 32'h0, 0, 0, 0, 3'b000, "R2 set cause 2");
    op(12'h004, 1, 2'd0, 32'h0004_0004, 0, 0, 0, 3'b000, "R5 event beats clear");
    op(12'h001, 0, 2'd3, 32'h0, 0, 0, 1, 3'b000, "R7 masked completion");
    op(12'h001, 1, 2'd1, 32'h0000_0001, 0, 0, 0, 3'b000, "R2 completion sets, R4");
    op(12'h000, 0, 2'd3, 32'h0, 1, 1, 0, 3'b000, "R6 slot read ignored in w1c mode");
    op(12'h000, 0, 2'd3, 32'h0, 0, 1, 0, 3'b000, "R6 slot read clears");
    op(12'h700, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, 0, 3'b000, "R10 wide enable write, R2");
    op(12'h000, 0, 2'd3, 32'h0, 0, 0, 0, 3'b101, "R8 counter clears");
    op(12'h000, 0, 2'd3, 32'h0, 0, 0, 0, 3'b010, "R8 counter clears 9");
    op(12'h0F0, 0, 2'd3, 32'h0, 0, 0, 0, 3'b000, "R2 masked view, R9");
    op(12'h000, 1, 2'd2, 32'hFFFF_F0F4, 0, 0, 0, 3'b000, "R4 enable clear, R9");
    op(12'h000, 1, 2'd0, 32'hF000_F000, 0, 0, 0, 3'b000, "R10 spare bits ignored");
    op(12'h000, 1, 2'd2, 32'h0000_0F0F, 0, 0, 0, 3'b000, "R4 clear rest, R9 low");
    idle();
    repeat (3) @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule